// File: doc/BRIEF.md
# Set-Associative Tag Lookup with Least-Recently-Used Replacement

This block is the placement, lookup and replacement core of a small cache. A requester presents a block address with a valid strobe. The low address bits pick a set, which is the block number modulo the set count. The remaining bits form the tag. The tag is compared against every way of that set at once, with one comparator per way. Within the same cycle the block reports a hit or a miss, the way that hit, and the way that a miss will fill. It also returns the stored word of the hitting way.

Backing memory is modelled as an immediate fill. On a miss, the word offered with the request is returned at once and is written, together with the new tag, into the chosen way at the next clock edge. The chosen way is the lowest-numbered invalid way of the set if one exists. Otherwise it is the least recently used way. Recency is kept in one of three forms, picked by the way count: none for one way, a single bit per set for two ways, and a per-way age ranking per set for four ways. One set holding all entries gives a fully associative lookup.

Top module: `assoc_lookup`

## Requirements
- R1: The set index is the low log2(SETS) bits of `req_addr` and the tag is the remaining upper bits. Accesses to one set never change the contents or recency of another set. In the default build (4 sets), address 0x05 falls in set 1 and address 0x04 in set 0.
- R2: When `req_valid` is high and a valid way of the selected set holds the request tag, `hit` is 1 and `miss` is 0 in the same cycle. `hit_way` gives that way's number and `rd_data` its stored word.
- R3: When `req_valid` is high and no way matches, `miss` is 1 and `rd_data` equals `req_wdata`. If the set has an invalid way, `victim_way` is the lowest-numbered invalid way. After the next clock edge that way holds the tag and the word.
- R4: On a miss with every way of the set valid, `victim_way` is the way least recently accessed, and that way is overwritten.
- R5: Every hit and every fill makes the accessed way the most recently used of its set.
- R6: Reset (`rst_n` low) clears every valid bit and returns each set's recency to a fixed order. Afterwards, the first access to any address misses and fills way 0.
- R7: While `req_valid` is low, `hit` and `miss` are both 0, and no tag, word, valid bit or recency state changes.
- R8: With WAYS=1 the block is direct mapped, so two tags sharing a set evict each other. With SETS=1 every way takes any address, so the block is fully associative.
- R9: With WAYS=2, one bit per set records the older way. A hit on way 0 makes way 1 the next victim, and the reverse holds as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | ADDR_W | Block address |
| req_wdata | input | DATA_W | Word installed on a miss (immediate fill) |
| hit | output | 1 | Request hit in the selected set |
| miss | output | 1 | Request missed |
| hit_way | output | max(1,log2(WAYS)) | Way that hit |
| victim_way | output | max(1,log2(WAYS)) | Way a miss fills |
| rd_data | output | DATA_W | Stored word on a hit, `req_wdata` on a miss |

## Verification
A miss in a full set does two things in one clock edge. It picks the oldest way as the victim, and it moves that same way to the top of the recency order. A wrong update ordering therefore shows up only on the next miss in that set. The bench provokes this with back-to-back requests to a single set: it fills all ways, mixes hits in, then issues two consecutive evicting misses. For each miss it compares `victim_way` with an age order tracked by hand. It then checks that the evicted tag misses and that the kept tags still hit with their words.

// File: rtl/assoc_lookup.sv
module assoc_lookup #(
  parameter int WAYS   = 4,
  parameter int SETS   = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              hit,
  output logic              miss,
  output logic [((WAYS>1)?$clog2(WAYS):1)-1:0] hit_way,
  output logic [((WAYS>1)?$clog2(WAYS):1)-1:0] victim_way,
  output logic [DATA_W-1:0] rd_data
);
  localparam int SET_W = $clog2(SETS);
  localparam int IDX_W = (SET_W > 0) ? SET_W : 1;
  localparam int TAG_W = ADDR_W - SET_W;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
  logic [DATA_W-1:0] data_q [SETS][WAYS];
  logic [WAYS-1:0]   valid_q [SETS];

  logic [IDX_W-1:0] set_idx;
  logic [TAG_W-1:0] req_tag;
  logic [WAYS-1:0]  match_vec;
  logic [WAYS-1:0]  vset;
  logic             hit_any, has_free;
  logic [WAY_W-1:0] hit_w, free_w, lru_w, acc_w;

  generate
    if (SET_W > 0) begin : g_idx
      assign set_idx = req_addr[SET_W-1:0];
    end else begin : g_noidx
      assign set_idx = '0;
    end
  endgenerate

  assign req_tag = req_addr[ADDR_W-1:SET_W];
  assign vset    = valid_q[set_idx];

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign match_vec[w] = vset[w] && (tag_q[set_idx][w] == req_tag);
    end
  endgenerate

  always_comb begin
    hit_w = '0;
    for (int w = 0; w < WAYS; w++)
      if (match_vec[w]) hit_w = WAY_W'(w);
  end

  always_comb begin
    free_w = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (!vset[w]) free_w = WAY_W'(w);
  end

  assign hit_any  = |match_vec;
  assign has_free = ~&vset;
  assign victim_way = has_free ? free_w : lru_w;
  assign acc_w    = hit_any ? hit_w : victim_way;

  assign hit     = req_valid && hit_any;
  assign miss    = req_valid && !hit_any;
  assign hit_way = hit_w;
  assign rd_data = hit_any ? data_q[set_idx][hit_w] : req_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else if (miss) begin
      valid_q[set_idx][acc_w] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (miss) begin
      tag_q[set_idx][acc_w]  <= req_tag;
      data_q[set_idx][acc_w] <= req_wdata;
    end
  end

  generate
    if (WAYS == 1) begin : g_lru_none
      assign lru_w = '0;
    end else if (WAYS == 2) begin : g_lru_bit
      logic [SETS-1:0] old_q;
      assign lru_w = old_q[set_idx];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) old_q <= '1;
        else if (req_valid) old_q[set_idx] <= ~acc_w[0];
      end
    end else begin : g_lru_age
      logic [WAY_W-1:0] age_q [SETS][WAYS];
      always_comb begin
        lru_w = '0;
        for (int w = 0; w < WAYS; w++)
          if (age_q[set_idx][w] == WAY_W'(WAYS - 1)) lru_w = WAY_W'(w);
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
        end else if (req_valid) begin
          for (int w = 0; w < WAYS; w++) begin
            if (WAY_W'(w) == acc_w)
              age_q[set_idx][w] <= '0;
            else if (age_q[set_idx][w] < age_q[set_idx][acc_w])
              age_q[set_idx][w] <= age_q[set_idx][w] + 1'b1;
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/assoc_lookup_chk.sv
module assoc_lookup_chk #(
  parameter int WAYS   = 4,
  parameter int ADDR_W = 8,
  parameter int WAY_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              hit,
  input logic              miss,
  input logic [WAY_W-1:0]  hit_way,
  input logic [WAY_W-1:0]  victim_way,
  input logic [WAYS-1:0]   match_vec
);
  logic              armed, prev_miss;
  logic [ADDR_W-1:0] prev_addr;
  logic [WAY_W-1:0]  prev_victim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed       <= 1'b0;
      prev_miss   <= 1'b0;
      prev_addr   <= '0;
      prev_victim <= '0;
    end else begin
      armed       <= 1'b1;
      prev_miss   <= miss;
      prev_addr   <= req_addr;
      prev_victim <= victim_way;
    end
  end

  a_r2_hit_miss_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit && miss));

  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!hit && !miss));

  a_r2_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));

  a_r3_fill_then_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && prev_miss && req_valid && req_addr == prev_addr) |->
      (hit && hit_way == prev_victim));
endmodule

bind assoc_lookup assoc_lookup_chk #(
  .WAYS(WAYS), .ADDR_W(ADDR_W), .WAY_W(WAY_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .hit(hit), .miss(miss), .hit_way(hit_way), .victim_way(victim_way),
  .match_vec(match_vec)
);

// File: tb/assoc_lookup_tb_top.sv
`timescale 1ns/1ps
module assoc_lookup_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  int checks = 0;
  int errs = 0;

  always #2.5 clk = ~clk;

  logic hit, miss;
  logic [1:0] hit_way, victim_way;
  logic [15:0] rd_data;
  assoc_lookup #(.WAYS(4), .SETS(4), .ADDR_W(8), .DATA_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_wdata(req_wdata), .hit(hit), .miss(miss), .hit_way(hit_way),
    .victim_way(victim_way), .rd_data(rd_data));

  logic dm_hit, dm_miss;
  logic [0:0] dm_hw, dm_vw;
  logic [15:0] dm_rd;
  assoc_lookup #(.WAYS(1), .SETS(4), .ADDR_W(8), .DATA_W(16)) dm_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_wdata(req_wdata), .hit(dm_hit), .miss(dm_miss), .hit_way(dm_hw),
    .victim_way(dm_vw), .rd_data(dm_rd));

  logic w2_hit, w2_miss;
  logic [0:0] w2_hw, w2_vw;
  logic [15:0] w2_rd;
  assoc_lookup #(.WAYS(2), .SETS(4), .ADDR_W(8), .DATA_W(16)) w2_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_wdata(req_wdata), .hit(w2_hit), .miss(w2_miss), .hit_way(w2_hw),
    .victim_way(w2_vw), .rd_data(w2_rd));

  logic fa_hit, fa_miss;
  logic [1:0] fa_hw, fa_vw;
  logic [15:0] fa_rd;
  assoc_lookup #(.WAYS(4), .SETS(1), .ADDR_W(8), .DATA_W(16)) fa_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_wdata(req_wdata), .hit(fa_hit), .miss(fa_miss), .hit_way(fa_hw),
    .victim_way(fa_vw), .rd_data(fa_rd));

  // {addr[8], wdata[16], exp_hit[1], exp_way[2], exp_rd[16]}
  localparam int NV = 11;
  localparam logic [42:0] VEC [NV] = '{
    {8'h04, 16'hA001, 1'b0, 2'd0, 16'hA001},
    {8'h08, 16'hA002, 1'b0, 2'd1, 16'hA002},
    {8'h0C, 16'hA003, 1'b0, 2'd2, 16'hA003},
    {8'h10, 16'hA004, 1'b0, 2'd3, 16'hA004},
    {8'h04, 16'h0000, 1'b1, 2'd0, 16'hA001},
    {8'h14, 16'hA006, 1'b0, 2'd1, 16'hA006},
    {8'h08, 16'hA007, 1'b0, 2'd2, 16'hA007},
    {8'h10, 16'h0000, 1'b1, 2'd3, 16'hA004},
    {8'h14, 16'h0000, 1'b1, 2'd1, 16'hA006},
    {8'h05, 16'hA00A, 1'b0, 2'd0, 16'hA00A},
    {8'h04, 16'h0000, 1'b1, 2'd0, 16'hA001}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    req_valid = v;
    req_addr  = a;
    req_wdata = d;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #1000000;
    checks++;
    errs++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - errs, checks);
    $finish;
  end

  initial begin
    do_reset();
    #1;
    chk("R6 idle hit after reset", {31'd0, hit}, 0);
    chk("R6 idle miss after reset", {31'd0, miss}, 0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = VEC[i][18] ? "R2" : ((i == 5 || i == 6) ? "R4" : "R3");
      if (i >= 9) tag = "R1";
      drive(1'b1, VEC[i][42:35], VEC[i][34:19]);
      chk($sformatf("%s vec%0d hit", tag, i), {31'd0, hit}, {31'd0, VEC[i][18]});
      chk($sformatf("%s vec%0d miss", tag, i), {31'd0, miss}, {31'd0, ~VEC[i][18]});
      if (VEC[i][18])
        chk($sformatf("%s vec%0d hit_way", tag, i), {30'd0, hit_way}, {30'd0, VEC[i][17:16]});
      else
        chk($sformatf("%s R5 vec%0d victim_way", tag, i), {30'd0, victim_way}, {30'd0, VEC[i][17:16]});
      chk($sformatf("%s vec%0d rd_data", tag, i), {16'd0, rd_data}, {16'd0, VEC[i][15:0]});
    end

    drive(1'b0, 8'h0C, 16'hBEEF);
    chk("R7 idle hit", {31'd0, hit}, 0);
    chk("R7 idle miss", {31'd0, miss}, 0);
    drive(1'b1, 8'h0C, 16'hB00C);
    chk("R7 no fill while idle", {31'd0, miss}, 1);
    chk("R4 R5 victim after hits", {30'd0, victim_way}, 2);
    drive(1'b1, 8'h0C, 16'h0000);
    chk("R3 refill hit way", {30'd0, hit_way}, 2);
    chk("R3 refill data", {16'd0, rd_data}, 16'hB00C);

    do_reset();
    drive(1'b1, 8'h04, 16'hC001);
    chk("R6 miss after reset", {31'd0, miss}, 1);
    chk("R6 way0 after reset", {30'd0, victim_way}, 0);
    chk("R8 dm first miss", {31'd0, dm_miss}, 1);
    chk("R9 w2 first victim", {31'd0, w2_vw}, 0);
    chk("R8 fa first victim", {30'd0, fa_vw}, 0);
    drive(1'b1, 8'h08, 16'hC002);
    chk("R8 dm second miss", {31'd0, dm_miss}, 1);
    chk("R9 w2 second victim", {31'd0, w2_vw}, 1);
    chk("R8 fa second victim", {30'd0, fa_vw}, 1);
    drive(1'b1, 8'h04, 16'h0000);
    chk("R8 dm conflict miss", {31'd0, dm_miss}, 1);
    chk("R9 w2 hit way0", {31'd0, w2_hit}, 1);
    chk("R9 w2 hit way0 id", {31'd0, w2_hw}, 0);
    chk("R8 fa hit", {31'd0, fa_hit}, 1);
    chk("R8 fa hit data", {16'd0, fa_rd}, 16'hC001);
    drive(1'b1, 8'h0C, 16'hC004);
    chk("R9 w2 evict way1", {31'd0, w2_vw}, 1);
    chk("R8 fa third victim", {30'd0, fa_vw}, 2);
    drive(1'b1, 8'h08, 16'hC005);
    chk("R9 w2 evict way0", {31'd0, w2_vw}, 0);
    chk("R9 w2 miss", {31'd0, w2_miss}, 1);
    chk("R8 fa keeps all", {31'd0, fa_hit}, 1);
    chk("R8 fa hit way1", {30'd0, fa_hw}, 1);
    chk("R8 dm rd on miss", {16'd0, dm_rd}, 16'hC005);

    drive(1'b0, 8'h00, 16'h0000);
    $display("%0d/%0d checks passed", checks - errs, checks);
    $finish;
  end
endmodule